// File: doc/BRIEF.md
# Coalesced EOI Tracker

This block watches one edge-triggered interrupt pin and decides whether a new assertion of that pin must be reported as coalesced. The decision depends on whether any earlier delivery is still waiting for an end-of-interrupt (EOI) acknowledgement. When a delivery is accepted, the block records which CPUs received the interrupt and the vector each one was sent. It keeps a count of the acknowledgements still outstanding. EOI events retire entries only when both the CPU's bit and its recorded vector match.

Delivery results come in over a valid/ready stream. The tracker raises ready only when nothing is outstanding and no reload is in progress, so a new delivery can never overwrite live tracking state. A producer holding valid against a low ready keeps its map, vector and fail flag stable until it is accepted.

EOI events, per-CPU resync updates and the reload strobe are single-cycle pulses. They have no handshake. A resync pulse reports whether one CPU currently has the tracked interrupt pending. If a decrement would take the count below zero, the tracker discards its bitmap and rebuilds it from a vector of per-CPU pending indications.

Top module: `eoi_coalesce_tracker`

## Requirements
- R1: With `query_i` high, `coalesced_o` is 1 exactly when the outstanding count is non-zero, and `grant_o` is 1 exactly when it is zero. With `query_i` low, both outputs are 0.
- R2: `dlv_ready_o` is 1 only while the outstanding count is zero and `reload_i` is low. A delivery transfers on a cycle where `dlv_valid_i` and `dlv_ready_o` are both 1.
- R3: An accepted delivery has these effects:
  - It loads the bitmap from `dlv_map_i`, where bit i stands for CPU i.
  - It records `dlv_vec_i` for every CPU whose bit is set.
  - It sets the count to the number of ones in the map, or to 0 when `dlv_fail_i` is 1.
- R4: An EOI whose CPU has its bit set, and whose vector equals the vector recorded for that CPU, clears that bit and lowers the count by one.
- R5: An EOI from a CPU whose bit is clear, or whose vector differs from the recorded one, changes neither the bitmap nor the count. This also holds for a CPU number of `NUM_CPU` or more.
- R6: Reset and a `reload_i` pulse clear the whole bitmap and set the count to 0.
- R7: A resync pulse sets or clears the bit for `sync_cpu_i` according to `sync_pend_i`:
  - On a set, it records `sync_vec_i` for that CPU.
  - The count rises or falls by one only when the bit actually changes.
  - A pulse that leaves the bit as it was has no effect.
- R8: The count never goes below zero. A decrement that would do so instead loads the bitmap from `rb_pend_i` and sets the count to the number of ones in it. Every CPU marked in `rb_pend_i` takes the vector of the event that triggered the rebuild (the EOI vector or `sync_vec_i`).
- R9: Only one state update is made per cycle, chosen in this priority order: reload, then accepted delivery, then a resync that changes a bit, then a matching EOI. Lower-priority events in the same cycle are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reload_i | input | 1 | Pulse: discard all tracking state |
| query_i | input | 1 | The designated pin is being asserted |
| coalesced_o | output | 1 | Assertion must be reported as coalesced |
| grant_o | output | 1 | Assertion may be delivered |
| dlv_valid_i | input | 1 | Delivery result valid |
| dlv_ready_o | output | 1 | Tracker can accept a delivery result |
| dlv_map_i | input | NUM_CPU | CPUs reached by the delivery |
| dlv_vec_i | input | VEC_W | Vector sent with the delivery |
| dlv_fail_i | input | 1 | Delivery failed; count loads 0 |
| eoi_valid_i | input | 1 | EOI event pulse |
| eoi_cpu_i | input | CPU_W | CPU issuing the EOI |
| eoi_vec_i | input | VEC_W | Vector acknowledged |
| sync_valid_i | input | 1 | Resync pulse |
| sync_cpu_i | input | CPU_W | CPU being resynchronised |
| sync_pend_i | input | 1 | That CPU has the interrupt pending |
| sync_vec_i | input | VEC_W | Vector recorded on a set |
| rb_pend_i | input | NUM_CPU | Per-CPU pending indications used by a rebuild |

## Verification
The in-module properties check these behaviours on every clocked cycle:
- the count loaded by a successful delivery;
- the single-step decrement and bitmap shrink on a matching EOI;
- that a non-matching EOI or a no-change resync leaves the state alone;
- the cleared state after reload;
- that the counter is never asked to step below zero or above `NUM_CPU`.

Some behaviours only the bench's scenarios can show:
- that the vector recorded per CPU is the one later compared;
- that a rebuild draws its bitmap from the pending inputs;
- that coincident events resolve in the stated priority.

The bench shows these through the coalesced flag and ready after sequences of events, including a sweep over every non-empty delivery map.

// File: rtl/eoi_trk_pkg.sv
package eoi_trk_pkg;
  typedef enum logic [2:0] {
    MOP_IDLE,
    MOP_WIPE,
    MOP_LOAD,
    MOP_SET,
    MOP_CLR
  } map_op_e;

  typedef enum logic [2:0] {
    COP_HOLD,
    COP_ZERO,
    COP_LOAD,
    COP_INC,
    COP_DEC
  } cnt_op_e;
endpackage

// File: rtl/eoi_trk_map.sv
module eoi_trk_map
  import eoi_trk_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int VEC_W   = 8,
  parameter int CPU_W   = 3
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  map_op_e                         op_i,
  input  logic [CPU_W-1:0]                cpu_i,
  input  logic [VEC_W-1:0]                vec_i,
  input  logic [NUM_CPU-1:0]              bits_i,
  output logic [NUM_CPU-1:0]              pend_o,
  output logic [NUM_CPU-1:0][VEC_W-1:0]   vec_o
);
  // One slot per CPU: a pending bit plus the vector recorded when it was set.
  for (genvar g = 0; g < NUM_CPU; g++) begin : g_slot
    logic hit;
    assign hit = (cpu_i == CPU_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_o[g] <= 1'b0;
        vec_o[g]  <= '0;
      end else begin
        unique case (op_i)
          MOP_WIPE: pend_o[g] <= 1'b0;
          MOP_LOAD: begin
            pend_o[g] <= bits_i[g];
            if (bits_i[g]) vec_o[g] <= vec_i;
          end
          MOP_SET: if (hit) begin
            pend_o[g] <= 1'b1;
            vec_o[g]  <= vec_i;
          end
          MOP_CLR: if (hit) pend_o[g] <= 1'b0;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/eoi_trk_count.sv
module eoi_trk_count
  import eoi_trk_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int CNT_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cnt_op_e          op_i,
  input  logic [CNT_W-1:0] val_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
    end else begin
      unique case (op_i)
        COP_ZERO: cnt_o <= '0;
        COP_LOAD: cnt_o <= val_i;
        COP_INC:  cnt_o <= cnt_o + 1'b1;
        COP_DEC:  cnt_o <= cnt_o - 1'b1;
        default:  ;
      endcase
    end
  end

  // The control never steps the counter out of 0..NUM_CPU.
  p_no_underflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == COP_DEC) |-> (cnt_o != '0));
  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == COP_INC) |-> (32'(cnt_o) < NUM_CPU));
endmodule

// File: rtl/eoi_coalesce_tracker.sv
module eoi_coalesce_tracker
  import eoi_trk_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int VEC_W   = 8,
  parameter int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reload_i,
  input  logic                 query_i,
  output logic                 coalesced_o,
  output logic                 grant_o,
  input  logic                 dlv_valid_i,
  output logic                 dlv_ready_o,
  input  logic [NUM_CPU-1:0]   dlv_map_i,
  input  logic [VEC_W-1:0]     dlv_vec_i,
  input  logic                 dlv_fail_i,
  input  logic                 eoi_valid_i,
  input  logic [CPU_W-1:0]     eoi_cpu_i,
  input  logic [VEC_W-1:0]     eoi_vec_i,
  input  logic                 sync_valid_i,
  input  logic [CPU_W-1:0]     sync_cpu_i,
  input  logic                 sync_pend_i,
  input  logic [VEC_W-1:0]     sync_vec_i,
  input  logic [NUM_CPU-1:0]   rb_pend_i
);
  localparam int CNT_W = $clog2(NUM_CPU + 1);
  localparam int SLOTS = 1 << CPU_W;

  logic [NUM_CPU-1:0]            pend_map;
  logic [NUM_CPU-1:0][VEC_W-1:0] vec_tab;
  logic [CNT_W-1:0]              cnt;

  // Index space padded to a power of two; missing CPUs read as never pending.
  logic [SLOTS-1:0]              map_pad;
  logic [SLOTS-1:0][VEC_W-1:0]   vec_pad;
  for (genvar s = 0; s < SLOTS; s++) begin : g_pad
    if (s < NUM_CPU) begin : g_real
      assign map_pad[s] = pend_map[s];
      assign vec_pad[s] = vec_tab[s];
    end else begin : g_none
      assign map_pad[s] = 1'b0;
      assign vec_pad[s] = '0;
    end
  end

  logic cnt_zero, dlv_acc, sync_chg, eoi_hit;
  assign cnt_zero    = (cnt == '0);
  assign dlv_ready_o = cnt_zero && !reload_i;
  assign dlv_acc     = dlv_valid_i && dlv_ready_o;
  assign sync_chg    = sync_valid_i && (map_pad[sync_cpu_i] != sync_pend_i)
                       && (sync_pend_i || map_pad[sync_cpu_i]);
  assign eoi_hit     = eoi_valid_i && map_pad[eoi_cpu_i]
                       && (vec_pad[eoi_cpu_i] == eoi_vec_i);

  assign coalesced_o = query_i && !cnt_zero;
  assign grant_o     = query_i && cnt_zero;

  map_op_e             mop;
  cnt_op_e             cop;
  logic [CPU_W-1:0]    m_cpu;
  logic [VEC_W-1:0]    m_vec;
  logic [NUM_CPU-1:0]  m_bits;
  logic [CNT_W-1:0]    c_val;

  always_comb begin
    mop    = MOP_IDLE;
    cop    = COP_HOLD;
    m_cpu  = sync_cpu_i;
    m_vec  = sync_vec_i;
    m_bits = dlv_map_i;
    if (reload_i) begin
      mop = MOP_WIPE;
      cop = COP_ZERO;
    end else if (dlv_acc) begin
      mop   = MOP_LOAD;
      m_vec = dlv_vec_i;
      cop   = dlv_fail_i ? COP_ZERO : COP_LOAD;
    end else if (sync_chg) begin
      if (sync_pend_i) begin
        mop = MOP_SET;
        cop = COP_INC;
      end else if (cnt_zero) begin
        mop    = MOP_LOAD;
        m_bits = rb_pend_i;
        cop    = COP_LOAD;
      end else begin
        mop = MOP_CLR;
        cop = COP_DEC;
      end
    end else if (eoi_hit) begin
      m_cpu = eoi_cpu_i;
      m_vec = eoi_vec_i;
      if (cnt_zero) begin
        mop    = MOP_LOAD;
        m_bits = rb_pend_i;
        cop    = COP_LOAD;
      end else begin
        mop = MOP_CLR;
        cop = COP_DEC;
      end
    end
    c_val = CNT_W'($countones(m_bits));
  end

  eoi_trk_map #(.NUM_CPU(NUM_CPU), .VEC_W(VEC_W), .CPU_W(CPU_W)) map_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (mop),
    .cpu_i  (m_cpu),
    .vec_i  (m_vec),
    .bits_i (m_bits),
    .pend_o (pend_map),
    .vec_o  (vec_tab)
  );

  eoi_trk_count #(.NUM_CPU(NUM_CPU), .CNT_W(CNT_W)) cnt_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (cop),
    .val_i  (c_val),
    .cnt_o  (cnt)
  );

  // R1/R2: a coalesced report and an open delivery port never coincide.
  p_coal_blocks_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coalesced_o |-> !dlv_ready_o);

  // R3: a good delivery leaves the count equal to the map's population.
  p_dlv_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dlv_acc && !dlv_fail_i && !reload_i)
      |=> (cnt == $past(CNT_W'($countones(dlv_map_i)))));

  // R4: a matching EOI retires exactly one entry.
  p_eoi_retire_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_hit && !cnt_zero && !reload_i && !dlv_acc && !sync_chg)
      |=> (cnt == $past(cnt) - 1'b1)
          && ($countones(pend_map) == $countones($past(pend_map)) - 1));

  // R5: a non-matching EOI alone touches nothing.
  p_eoi_miss_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_valid_i && !eoi_hit && !reload_i && !dlv_acc && !sync_valid_i)
      |=> ($stable(cnt) && $stable(pend_map)));

  // R6: reload empties the tracker.
  p_reload_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> (cnt == '0) && (pend_map == '0));

  // R7: a resync that matches the current bit changes nothing.
  p_sync_same_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_valid_i && !sync_chg && !reload_i && !dlv_acc && !eoi_valid_i)
      |=> ($stable(cnt) && $stable(pend_map)));
endmodule

// File: tb/eoi_coalesce_tracker_tb_top.sv
module eoi_coalesce_tracker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCPU = 8;
  localparam int VW   = 8;
  localparam int CW   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic            reload = 0, query = 1, coal, grant;
  logic            dlv_valid = 0, dlv_ready, dlv_fail = 0;
  logic [NCPU-1:0] dlv_map = '0, rb_pend = '0;
  logic [VW-1:0]   dlv_vec = '0, eoi_vec = '0, sync_vec = '0;
  logic            eoi_valid = 0, sync_valid = 0, sync_pend = 0;
  logic [CW-1:0]   eoi_cpu = '0, sync_cpu = '0;

  int n_chk = 0;
  int n_bad = 0;

  eoi_coalesce_tracker #(.NUM_CPU(NCPU), .VEC_W(VW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reload_i(reload), .query_i(query),
    .coalesced_o(coal), .grant_o(grant),
    .dlv_valid_i(dlv_valid), .dlv_ready_o(dlv_ready), .dlv_map_i(dlv_map),
    .dlv_vec_i(dlv_vec), .dlv_fail_i(dlv_fail),
    .eoi_valid_i(eoi_valid), .eoi_cpu_i(eoi_cpu), .eoi_vec_i(eoi_vec),
    .sync_valid_i(sync_valid), .sync_cpu_i(sync_cpu), .sync_pend_i(sync_pend),
    .sync_vec_i(sync_vec), .rb_pend_i(rb_pend)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // All stimulus is applied just after a falling edge and removed one cycle later.
  task automatic deliver(input logic [NCPU-1:0] m, input logic [VW-1:0] v, input logic f);
    dlv_valid = 1; dlv_map = m; dlv_vec = v; dlv_fail = f;
    @(negedge clk);
    dlv_valid = 0; dlv_fail = 0;
  endtask

  task automatic eoi(input int c, input logic [VW-1:0] v);
    eoi_valid = 1; eoi_cpu = CW'(c); eoi_vec = v;
    @(negedge clk);
    eoi_valid = 0;
  endtask

  task automatic rsync(input int c, input logic p, input logic [VW-1:0] v);
    sync_valid = 1; sync_cpu = CW'(c); sync_pend = p; sync_vec = v;
    @(negedge clk);
    sync_valid = 0;
  endtask

  task automatic run();
    repeat (3) @(negedge clk);
    // Reset state.
    chk("R6 reset coalesced", 32'(coal), 0);
    chk("R1 reset grant", 32'(grant), 1);
    chk("R2 reset ready", 32'(dlv_ready), 1);
    rst_n = 1;
    @(negedge clk);

    // Sweep every non-empty delivery map.
    for (int m = 1; m < 256; m++) begin
      logic [VW-1:0] v;
      int rem;
      v   = VW'(m) ^ 8'hA5;
      rem = $countones(m);
      chk("R2 ready when idle", 32'(dlv_ready), 1);
      deliver(NCPU'(m), v, 1'b0);
      chk("R1 coalesced after delivery", 32'(coal), 1);
      chk("R2 ready dropped while pending", 32'(dlv_ready), 0);
      for (int c = 0; c < NCPU; c++) begin
        if (!m[c]) begin
          eoi(c, v);
          chk("R5 eoi from clear cpu", 32'(coal), 1);
        end
      end
      for (int c = 0; c < NCPU; c++) begin
        if (m[c]) begin
          eoi(c, v ^ 8'h01);
          chk("R5 eoi wrong vector", 32'(coal), 1);
          eoi(c, v);
          rem--;
          chk("R4 matching eoi", 32'(coal), 32'(rem > 0));
        end
      end
      chk("R3 count equals population", 32'(dlv_ready), 1);
    end

    // R1: query low hides both outputs.
    deliver(8'h81, 8'h10, 1'b0);
    query = 0;
    #1;
    chk("R1 no query coalesced", 32'(coal), 0);
    chk("R1 no query grant", 32'(grant), 0);
    query = 1;
    #1;
    chk("R1 query grant low", 32'(grant), 0);

    // R6: reload clears everything; ready is blocked during reload (R2).
    reload = 1;
    #1;
    chk("R2 ready low in reload", 32'(dlv_ready), 0);
    @(negedge clk);
    reload = 0;
    chk("R6 reload clears count", 32'(coal), 0);
    eoi(0, 8'h10);
    chk("R6 reload cleared bitmap", 32'(coal), 0);

    // R3 failure, then R8 rebuild on an EOI underflow.
    deliver(8'h05, 8'h21, 1'b1);
    chk("R3 failed delivery count zero", 32'(coal), 0);
    chk("R3 failed delivery ready", 32'(dlv_ready), 1);
    rb_pend = 8'h06;
    eoi(0, 8'h21);
    rb_pend = '0;
    chk("R8 rebuild from pending", 32'(coal), 1);
    eoi(1, 8'h21);
    chk("R8 rebuilt vector cpu1", 32'(coal), 1);
    eoi(2, 8'h21);
    chk("R8 rebuilt vector cpu2", 32'(coal), 0);

    // R7 resync.
    rsync(4, 1'b1, 8'h33);
    chk("R7 sync set counts", 32'(coal), 1);
    rsync(4, 1'b1, 8'h33);
    eoi(4, 8'h33);
    chk("R7 repeated set no double count", 32'(coal), 0);
    rsync(6, 1'b0, 8'h00);
    chk("R7 clear of clear bit", 32'(dlv_ready), 1);
    rsync(6, 1'b1, 8'h44);
    eoi(6, 8'h45);
    chk("R7 vector recorded on set", 32'(coal), 1);
    eoi(6, 8'h44);
    chk("R7 vector match retires", 32'(coal), 0);
    rsync(3, 1'b1, 8'h50);
    rsync(3, 1'b0, 8'h50);
    chk("R7 sync clear decrements", 32'(coal), 0);

    // R8 via resync clear with count already zero.
    deliver(8'h08, 8'h60, 1'b1);
    rb_pend = 8'h10;
    rsync(3, 1'b0, 8'h55);
    rb_pend = '0;
    chk("R8 sync underflow rebuild", 32'(coal), 1);
    eoi(4, 8'h55);
    chk("R8 rebuild vector from sync", 32'(coal), 0);

    // R9: resync change wins over a coincident EOI.
    rsync(2, 1'b1, 8'h11);
    sync_valid = 1; sync_cpu = 3'd5; sync_pend = 1; sync_vec = 8'h12;
    eoi_valid = 1; eoi_cpu = 3'd2; eoi_vec = 8'h11;
    @(negedge clk);
    sync_valid = 0; eoi_valid = 0;
    eoi(2, 8'h11);
    chk("R9 eoi dropped under sync", 32'(coal), 1);
    eoi(5, 8'h12);
    chk("R9 both retired", 32'(coal), 0);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule